// File: doc/BRIEF.md
# Two-Bank Fast/Normal Interrupt Controller

This block gathers forty level-sensitive interrupt sources and presents them to a processor on two request lines: a fast request (FIQ) and a normal request (IRQ). Each source has an enable bit and a class bit. The class bit routes an enabled, pending source to the fast line when it is 1 and to the normal line when it is 0. Sources 0 to 31 live in the first bank. Sources 32 to 39 live in bits 7:0 of the second bank, and the unused upper bits of that bank read as zero.

A third output wakes an idle core. One idle-control bit selects whether only enabled sources can wake the core, or whether any pending source can, enabled or not. The wake output is only driven while the core reports that it is idle.

Software reaches the block through a single-cycle 32-bit register port. Writes take effect at the clock edge and reads are combinational. The block also stores a forty-entry priority table for a separate resolver. It exposes that table on a flat output bus and returns the resolver's result through a read-only register.

Top module: `fiq_irq_intc`

## Requirements
- R1: After reset the enable, class and pending bits of both banks are 0, the idle-control bit reads 0, every priority slot reads 0, and fiqOut, irqOut and wakeOut are low.
- R2: The pending bit of each source equals that source's input level as sampled at the previous clock edge; it is never latched. Raw pending reads at offset 0x10 for bank 1 and at 0xAC for bank 2.
- R3: Enable (0x04 / 0xA0) and class (0x08 / 0xA4, 1 = fast) registers read back the last value written, and bank-2 reads show zeros in bits 31:8.
- R4: The normal-pending view (0x00 / 0x9C) reads pending AND NOT class AND enable; the fast-pending view (0x0C / 0xA8) reads pending AND class AND enable.
- R5: fiqOut is high exactly when some source is pending, enabled and classed fast; irqOut is high exactly when some source is pending, enabled and classed normal.
- R6: Bit 0 of the idle register (0x14) is stored and read back. When it is 1, wakeOut = cpuIdle AND (some pending source is enabled). When it is 0, wakeOut = cpuIdle AND (some source is pending).
- R7: A write to a priority slot stores only bits 31 and 5:0. Slots 0-31 sit at 0x1C + 4*n and slots 32-39 at 0xB0 + 4*(n-32). Slot n appears on prioTable[7n+6:7n] as {bit31, bits5:0}.
- R8: A read at 0x18 returns bestResult unchanged.
- R9: Writes to the pending and status views, to 0x18, to unmapped or misaligned offsets have no effect on any register; unmapped and misaligned offsets read 0.
- R10: Source 32+k drives bit k of every bank-2 view, for k from 0 to 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| srcLevel | input | 40 | Level of each interrupt source |
| cpuIdle | input | 1 | High while the core is idle |
| regAddr | input | 8 | Register byte offset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| bestResult | input | 32 | Result from the external priority resolver |
| prioTable | output | 280 | Stored priority slots, 7 bits each |
| fiqOut | output | 1 | Fast interrupt request |
| irqOut | output | 1 | Normal interrupt request |
| wakeOut | output | 1 | Wake request to an idle core |

## Verification
Directed cases raise one bank-2 source at a time while its enable, class and idle-control bits change. This separates the fast line from the normal line, and enabled wake from unconditional wake, and it shows that the source reaches bit 3 of bank 2 and not bank 1. Bursts of writes with all ones aimed at read-only, unmapped and misaligned offsets show that no register is touched, because every stored value is read back afterwards. A seeded random phase mixes source levels, enable and class patterns, idle settings and writes to random offsets. After each step it compares all three outputs and a random register read with values from a bench model.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int SLOT_W = 6;
  localparam int PRIO_W = SLOT_W + 1;
  localparam int LO_SLOTS = 32;

  localparam logic [ADDR_W-1:0] OFF_IRQ0    = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_EN0     = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_CLS0    = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_FIQ0    = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_RAW0    = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_IDLE    = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_BEST    = 8'h18;
  localparam logic [ADDR_W-1:0] OFF_PRIO_LO = 8'h1C;
  localparam logic [ADDR_W-1:0] OFF_IRQ1    = 8'h9C;
  localparam logic [ADDR_W-1:0] OFF_EN1     = 8'hA0;
  localparam logic [ADDR_W-1:0] OFF_CLS1    = 8'hA4;
  localparam logic [ADDR_W-1:0] OFF_FIQ1    = 8'hA8;
  localparam logic [ADDR_W-1:0] OFF_RAW1    = 8'hAC;
  localparam logic [ADDR_W-1:0] OFF_PRIO_HI = 8'hB0;

  typedef enum logic [3:0] {
    RD_NONE, RD_IRQ0, RD_EN0, RD_CLS0, RD_FIQ0, RD_RAW0, RD_IDLE, RD_BEST,
    RD_PRIO, RD_IRQ1, RD_EN1, RD_CLS1, RD_FIQ1, RD_RAW1
  } rdSel_e;

  typedef struct packed {
    logic              wrEn0;
    logic              wrEn1;
    logic              wrCls0;
    logic              wrCls1;
    logic              wrIdle;
    logic              wrPrio;
    logic [SLOT_W-1:0] slot;
    rdSel_e            rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/intc_ctrl.sv
module intc_ctrl
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  output ctlStrobe_t        strb
);
  localparam int HI_SLOTS = NUM_SRC - LO_SLOTS;
  localparam logic [ADDR_W-1:0] LO_LAST = OFF_PRIO_LO + ADDR_W'(4 * (LO_SLOTS - 1));
  localparam logic [ADDR_W-1:0] HI_LAST = OFF_PRIO_HI + ADDR_W'(4 * (HI_SLOTS - 1));

  logic [ADDR_W-1:0] loDiff;
  logic [ADDR_W-1:0] hiDiff;

  assign loDiff = addr - OFF_PRIO_LO;
  assign hiDiff = addr - OFF_PRIO_HI;

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (addr[1:0] == 2'b00) begin
      unique case (addr)
        OFF_IRQ0: strb.rdSel = RD_IRQ0;
        OFF_FIQ0: strb.rdSel = RD_FIQ0;
        OFF_RAW0: strb.rdSel = RD_RAW0;
        OFF_BEST: strb.rdSel = RD_BEST;
        OFF_IRQ1: strb.rdSel = RD_IRQ1;
        OFF_FIQ1: strb.rdSel = RD_FIQ1;
        OFF_RAW1: strb.rdSel = RD_RAW1;
        OFF_EN0:  begin strb.rdSel = RD_EN0;  strb.wrEn0  = wrEn; end
        OFF_EN1:  begin strb.rdSel = RD_EN1;  strb.wrEn1  = wrEn; end
        OFF_CLS0: begin strb.rdSel = RD_CLS0; strb.wrCls0 = wrEn; end
        OFF_CLS1: begin strb.rdSel = RD_CLS1; strb.wrCls1 = wrEn; end
        OFF_IDLE: begin strb.rdSel = RD_IDLE; strb.wrIdle = wrEn; end
        default: begin
          if (addr >= OFF_PRIO_LO && addr <= LO_LAST) begin
            strb.rdSel  = RD_PRIO;
            strb.wrPrio = wrEn;
            strb.slot   = loDiff[SLOT_W+1:2];
          end else if (addr >= OFF_PRIO_HI && addr <= HI_LAST) begin
            strb.rdSel  = RD_PRIO;
            strb.wrPrio = wrEn;
            strb.slot   = SLOT_W'(LO_SLOTS) + hiDiff[SLOT_W+1:2];
          end
        end
      endcase
    end
  end

  // At most one storage element is written per cycle.
  assert_one_target_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrEn0, strb.wrEn1, strb.wrCls0, strb.wrCls1, strb.wrIdle, strb.wrPrio}));

  // A misaligned offset never produces a read selection or a write.
  assert_misaligned_quiet_R9: assert property (@(posedge clk) disable iff (!rstN)
    (addr[1:0] != 2'b00) |-> (strb.rdSel == RD_NONE && !strb.wrPrio && !strb.wrIdle));
endmodule

// File: rtl/intc_datapath.sv
module intc_datapath
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  ctlStrobe_t                strb,
  input  logic [NUM_SRC-1:0]        srcLevel,
  input  logic                      cpuIdle,
  input  logic [DATA_W-1:0]         wrData,
  input  logic [DATA_W-1:0]         bestResult,
  output logic [DATA_W-1:0]         rdData,
  output logic [NUM_SRC*PRIO_W-1:0] prioTable,
  output logic                      fiqOut,
  output logic                      irqOut,
  output logic                      wakeOut
);
  localparam int HI_W = NUM_SRC - LO_SLOTS;

  logic [LO_SLOTS-1:0] pend0, en0, cls0;
  logic [HI_W-1:0]     pend1, en1, cls1;
  logic                unmaskedOnly;
  logic [PRIO_W-1:0]   prio [NUM_SRC];

  logic [LO_SLOTS-1:0] irqV0, fiqV0, wake0;
  logic [HI_W-1:0]     irqV1, fiqV1, wake1;
  logic [PRIO_W-1:0]   prioRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pend0        <= '0;
      pend1        <= '0;
      en0          <= '0;
      en1          <= '0;
      cls0         <= '0;
      cls1         <= '0;
      unmaskedOnly <= 1'b0;
    end else begin
      pend0 <= srcLevel[LO_SLOTS-1:0];
      pend1 <= srcLevel[NUM_SRC-1:LO_SLOTS];
      if (strb.wrEn0)  en0  <= wrData[LO_SLOTS-1:0];
      if (strb.wrEn1)  en1  <= wrData[HI_W-1:0];
      if (strb.wrCls0) cls0 <= wrData[LO_SLOTS-1:0];
      if (strb.wrCls1) cls1 <= wrData[HI_W-1:0];
      if (strb.wrIdle) unmaskedOnly <= wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_SRC; i++) begin
      if (!rstN) begin
        prio[i] <= '0;
      end else if (strb.wrPrio && strb.slot == SLOT_W'(i)) begin
        prio[i] <= {wrData[DATA_W-1], wrData[SLOT_W-1:0]};
      end
    end
  end

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_flat
    assign prioTable[g*PRIO_W +: PRIO_W] = prio[g];
  end

  assign irqV0 = pend0 & ~cls0 & en0;
  assign irqV1 = pend1 & ~cls1 & en1;
  assign fiqV0 = pend0 & cls0 & en0;
  assign fiqV1 = pend1 & cls1 & en1;
  assign fiqOut = (|fiqV0) | (|fiqV1);
  assign irqOut = (|irqV0) | (|irqV1);

  assign wake0   = pend0 & (en0 | {LO_SLOTS{~unmaskedOnly}});
  assign wake1   = pend1 & (en1 | {HI_W{~unmaskedOnly}});
  assign wakeOut = cpuIdle & ((|wake0) | (|wake1));

  assign prioRd = (int'(strb.slot) < NUM_SRC) ? prio[strb.slot] : '0;

  always_comb begin
    unique case (strb.rdSel)
      RD_IRQ0: rdData = irqV0;
      RD_EN0:  rdData = en0;
      RD_CLS0: rdData = cls0;
      RD_FIQ0: rdData = fiqV0;
      RD_RAW0: rdData = pend0;
      RD_IDLE: rdData = {{(DATA_W-1){1'b0}}, unmaskedOnly};
      RD_BEST: rdData = bestResult;
      RD_PRIO: rdData = {prioRd[PRIO_W-1], {(DATA_W-PRIO_W){1'b0}}, prioRd[SLOT_W-1:0]};
      RD_IRQ1: rdData = DATA_W'(irqV1);
      RD_EN1:  rdData = DATA_W'(en1);
      RD_CLS1: rdData = DATA_W'(cls1);
      RD_FIQ1: rdData = DATA_W'(fiqV1);
      RD_RAW1: rdData = DATA_W'(pend1);
      default: rdData = '0;
    endcase
  end

  assert_pend_tracks_R2: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> ({pend1, pend0} == $past(srcLevel)));

  assert_fiq_needs_cfg_R5: assert property (@(posedge clk) disable iff (!rstN)
    fiqOut |-> (|({en1, en0} & {cls1, cls0} & $past(srcLevel))));

  assert_irq_needs_cfg_R5: assert property (@(posedge clk) disable iff (!rstN)
    irqOut |-> (|({en1, en0} & ~{cls1, cls0})));

  assert_wake_needs_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> (cpuIdle && (|{pend1, pend0})));

  assert_enable_holds_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.wrEn0) && $past(rstN) |-> $stable(en0));

  assert_views_disjoint_R4: assert property (@(posedge clk) disable iff (!rstN)
    ((irqV0 & fiqV0) == '0) && ((irqV1 & fiqV1) == '0));
endmodule

// File: rtl/fiq_irq_intc.sv
module fiq_irq_intc
  import intc_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_SRC-1:0]        srcLevel,
  input  logic                      cpuIdle,
  input  logic [ADDR_W-1:0]         regAddr,
  input  logic                      regWrEn,
  input  logic [DATA_W-1:0]         regWrData,
  output logic [DATA_W-1:0]         regRdData,
  input  logic [DATA_W-1:0]         bestResult,
  output logic [NUM_SRC*PRIO_W-1:0] prioTable,
  output logic                      fiqOut,
  output logic                      irqOut,
  output logic                      wakeOut
);
  ctlStrobe_t strb;

  intc_ctrl #(.NUM_SRC(NUM_SRC)) u_ctrl (
    .clk  (clk),
    .rstN (rstN),
    .addr (regAddr),
    .wrEn (regWrEn),
    .strb (strb)
  );

  intc_datapath #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .srcLevel   (srcLevel),
    .cpuIdle    (cpuIdle),
    .wrData     (regWrData),
    .bestResult (bestResult),
    .rdData     (regRdData),
    .prioTable  (prioTable),
    .fiqOut     (fiqOut),
    .irqOut     (irqOut),
    .wakeOut    (wakeOut)
  );
endmodule

// File: tb/fiq_irq_intc_bench.sv
`timescale 1ns/1ps
module fiq_irq_intc_bench;
  localparam int N = 40;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [N-1:0]  srcLevel = '0;
  logic          cpuIdle = 1'b0;
  logic [7:0]    regAddr = '0;
  logic          regWrEn = 1'b0;
  logic [31:0]   regWrData = '0;
  logic [31:0]   regRdData;
  logic [31:0]   bestResult = 32'h1234_5678;
  logic [N*7-1:0] prioTable;
  logic          fiqOut, irqOut, wakeOut;

  int checks = 0;
  int failures = 0;

  logic [N-1:0] eEn = '0, eCls = '0, ePend = '0;
  logic         eUnm = 1'b0;
  logic [6:0]   ePrio [N];

  always #10 clk = ~clk;

  fiq_irq_intc u_fiq_irq_intc (
    .clk(clk), .rstN(rstN), .srcLevel(srcLevel), .cpuIdle(cpuIdle),
    .regAddr(regAddr), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .bestResult(bestResult), .prioTable(prioTable),
    .fiqOut(fiqOut), .irqOut(irqOut), .wakeOut(wakeOut)
  );

  function automatic int slotOf(input logic [7:0] a);
    if (a[1:0] != 2'b00) return -1;
    if (a >= 8'h1C && a <= 8'h98) return (int'(a) - 'h1C) / 4;
    if (a >= 8'hB0 && a <= 8'hCC) return 32 + (int'(a) - 'hB0) / 4;
    return -1;
  endfunction

  function automatic logic [31:0] model(input logic [7:0] a);
    logic [N-1:0] irqV, fiqV;
    int s;
    irqV = ePend & ~eCls & eEn;
    fiqV = ePend & eCls & eEn;
    s = slotOf(a);
    if (s >= 0) return {ePrio[s][6], 25'b0, ePrio[s][5:0]};
    case (a)
      8'h00: return irqV[31:0];
      8'h04: return eEn[31:0];
      8'h08: return eCls[31:0];
      8'h0C: return fiqV[31:0];
      8'h10: return ePend[31:0];
      8'h14: return {31'b0, eUnm};
      8'h18: return bestResult;
      8'h9C: return {24'b0, irqV[39:32]};
      8'hA0: return {24'b0, eEn[39:32]};
      8'hA4: return {24'b0, eCls[39:32]};
      8'hA8: return {24'b0, fiqV[39:32]};
      8'hAC: return {24'b0, ePend[39:32]};
      default: return 32'h0;
    endcase
  endfunction

  task automatic applyWrite(input logic [7:0] a, input logic [31:0] d);
    int s;
    s = slotOf(a);
    if (s >= 0) ePrio[s] = {d[31], d[5:0]};
    else case (a)
      8'h04: eEn[31:0]  = d;
      8'hA0: eEn[39:32] = d[7:0];
      8'h08: eCls[31:0] = d;
      8'hA4: eCls[39:32] = d[7:0];
      8'h14: eUnm = d[0];
      default: ;
    endcase
  endtask

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // One clock: optional write, new source levels; model follows the edge.
  task automatic step(input logic wr, input logic [7:0] a, input logic [31:0] d,
                      input logic [N-1:0] src);
    @(negedge clk);
    regWrEn = wr; regAddr = a; regWrData = d; srcLevel = src;
    @(posedge clk);
    #1;
    if (wr) applyWrite(a, d);
    ePend = src;
    regWrEn = 1'b0;
  endtask

  task automatic checkRead(input string tag, input logic [7:0] a);
    regAddr = a;
    #1;
    check(tag, regRdData, model(a));
  endtask

  task automatic checkOuts(input string tag);
    logic [N-1:0] wk;
    wk = ePend & (eEn | {N{~eUnm}});
    check({tag, " fiqOut"}, {31'b0, fiqOut}, {31'b0, |(ePend & eCls & eEn)});
    check({tag, " irqOut"}, {31'b0, irqOut}, {31'b0, |(ePend & ~eCls & eEn)});
    check({tag, " wakeOut"}, {31'b0, wakeOut}, {31'b0, cpuIdle & (|wk)});
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] ros [10];
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) ePrio[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;

    // R1: reset state
    checkOuts("R1");
    foreach (ros[i]) ros[i] = 8'h00;
    for (int a = 0; a < 'hD0; a += 4) if (a != 'h18) checkRead("R1 reset read", 8'(a));
    check("R1 prioTable", prioTable[31:0], 32'h0);

    // R2 R10: source 35 raised, masked, wake on any pending
    cpuIdle = 1'b1;
    step(1'b0, 8'h00, 0, 40'h08_0000_0000);
    checkRead("R2 raw bank1", 8'h10);
    checkRead("R10 raw bank2 bit3", 8'hAC);
    check("R10 raw bank2 value", regRdData, 32'h08);
    checkOuts("R6 any-pending wake");
    // R6: only unmasked wake
    step(1'b1, 8'h14, 32'hFFFF_FFFF, 40'h08_0000_0000);
    checkRead("R6 idle readback", 8'h14);
    checkOuts("R6 masked no wake");
    // R5: enable bank-2 bit 3 as normal
    step(1'b1, 8'hA0, 32'hFFFF_FF08, 40'h08_0000_0000);
    checkRead("R3 bank2 enable upper zero", 8'hA0);
    checkOuts("R5 normal line");
    checkRead("R4 normal view bank2", 8'h9C);
    // R5: reclass as fast
    step(1'b1, 8'hA4, 32'h0000_0008, 40'h08_0000_0000);
    checkOuts("R5 fast line");
    checkRead("R4 fast view bank2", 8'hA8);
    checkRead("R4 normal view bank2 cleared", 8'h9C);
    cpuIdle = 1'b0;
    #1 checkOuts("R6 not idle");
    cpuIdle = 1'b1;
    // R2: level drop clears pending, not latched
    step(1'b0, 8'h00, 0, '0);
    checkOuts("R2 level drop");
    checkRead("R2 raw cleared", 8'hAC);

    // R9: writes to read-only, unmapped, misaligned offsets
    ros = '{8'h00, 8'h0C, 8'h10, 8'h18, 8'h9C, 8'hA8, 8'hAC, 8'hD0, 8'hFC, 8'h1E};
    foreach (ros[i]) step(1'b1, ros[i], 32'hFFFF_FFFF, '0);
    checkRead("R9 enable0 untouched", 8'h04);
    checkRead("R9 class0 untouched", 8'h08);
    checkRead("R9 enable1 untouched", 8'hA0);
    checkRead("R9 slot0 untouched", 8'h1C);
    checkRead("R9 unmapped reads zero", 8'hD0);
    checkRead("R9 misaligned reads zero", 8'h21);

    // R7: priority slot masking, both ranges
    step(1'b1, 8'h1C, 32'hFFFF_FFFF, '0);
    checkRead("R7 slot0", 8'h1C);
    check("R7 slot0 value", regRdData, 32'h8000_003F);
    step(1'b1, 8'hCC, 32'h7FFF_FF15, '0);
    checkRead("R7 slot39", 8'hCC);
    check("R7 slot39 table", {25'b0, prioTable[39*7 +: 7]}, 32'h15);
    check("R7 slot0 table", {25'b0, prioTable[6:0]}, 32'h7F);

    // R8: resolver result passthrough
    bestResult = 32'h8025_000A;
    checkRead("R8 best result", 8'h18);

    // Random phase
    for (int it = 0; it < 300; it++) begin
      logic [7:0] a;
      logic [31:0] d;
      logic [N-1:0] src;
      int pick;
      pick = $urandom_range(0, 9);
      case (pick)
        0: a = 8'h04;
        1: a = 8'hA0;
        2: a = 8'h08;
        3: a = 8'hA4;
        4: a = 8'h14;
        default: a = 8'($urandom_range(0, 255));
      endcase
      d = $urandom();
      src = {8'($urandom()), 32'($urandom())};
      cpuIdle = 1'($urandom());
      bestResult = $urandom();
      step(1'($urandom_range(0, 3) != 0), a, d, src);
      checkOuts("R5 R6 random");
      checkRead("R3 R4 random read", 8'($urandom_range(0, 255)));
      checkRead("R4 random normal view", 8'h00);
      checkRead("R4 random fast view", 8'hA8);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule